// File: doc/BRIEF.md
# Receive Character FIFO with Qualified Flush

This block buffers decoded receive characters between a line decoder and a downstream consumer. Characters enter through a valid/ready write port and leave in arrival order through a valid/ready read port, on a single clock. The store holds `DEPTH` characters of `WIDTH` bits. An `empty` and a `full` flag report its occupancy directly.

Software or a link controller can empty the store with an active-low flush request. The request only takes effect once it has been seen low on `QUAL_LEN` consecutive clock edges (seven by default). Each of those edges must also meet three conditions: the FIFO is in use, the consumer is not reading, and the chip enable is active. When the flush starts, the store is emptied at once. It then stays closed to new characters for as long as the request stays low. When the FIFO is bypassed, characters pass straight from the write port to the read port, and the flush request has no effect.

Back-pressure rules: a character moves on a port only on an edge where its valid and ready are both high. The producer must keep `in_data` steady while `in_valid` is high and `in_ready` is low. In bypass mode, `in_ready` follows `out_ready` and `out_valid` follows `in_valid` in the same cycle.

Top module: `rxq_fifo`

## Requirements
- R1: A flush starts on the `QUAL_LEN`-th (default 7th) consecutive qualifying clock edge and never on an earlier one.
- R2: An edge qualifies only when `flush_req_n`=0, `fifo_on`=1, `out_ready`=0 and `chip_en_n`=0. Any edge that fails one of these conditions restarts the count from zero.
- R3: On the edge where a flush starts, the occupancy, read pointer and write pointer are all cleared, so `empty`=1 right after that edge and `full`=0.
- R4: After a flush has started, and for as long as `flush_req_n` stays 0 with `fifo_on`=1, `in_ready`=0 and `out_valid`=0, and no character is stored.
- R5: `empty`=1 after a hardware reset and after a flush, and it stays 1 until a character is accepted on the write port.
- R6: With `fifo_on`=0, the flush request is ignored and the stored characters are kept. `out_valid`=`in_valid`, `out_data`=`in_data` and `in_ready`=`out_ready`.
- R7: `full`=1 exactly when the occupancy equals `DEPTH`. While full, `in_ready`=0 and a write attempt changes nothing.
- R8: While empty, `out_valid`=0 and a read attempt leaves the pointers and the occupancy unchanged.
- R9: Characters leave the read port in the order they were accepted, one per edge on which `out_valid` and `out_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| fifo_on | input | 1 | 1 = buffered mode, 0 = bypass |
| chip_en_n | input | 1 | Chip enable, active low; a condition for flush qualification |
| flush_req_n | input | 1 | Flush request, active low, qualified over `QUAL_LEN` edges |
| in_data | input | WIDTH | Character to write |
| in_valid | input | 1 | Write port valid |
| in_ready | output | 1 | Write port ready |
| out_data | output | WIDTH | Oldest character (or `in_data` in bypass) |
| out_valid | output | 1 | Read port valid |
| out_ready | input | 1 | Read port ready (read enable) |
| empty | output | 1 | Store holds no character |
| full | output | 1 | Store holds `DEPTH` characters |

## Verification
The hardest case to reach is a run of qualifying edges that stops one edge short of the threshold, or that is broken by a single failing edge and then restarts. Only an exact count shows whether the qualifier starts too early or forgets to restart. The bench sweeps the length of the low run from one edge past the threshold, with characters already stored, and expects the store to survive every run shorter than the threshold. It also inserts a single edge of chip disable, and separately a single high request edge, into a run. It then checks that the flush comes only after a full fresh run of `QUAL_LEN` edges.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic {
    PH_WATCH = 1'b0,
    PH_HOLD  = 1'b1
  } flush_phase_t;
endpackage

// File: rtl/rxq_flush_qual.sv
module rxq_flush_qual
  import rxq_pkg::*;
#(
  parameter int QUAL_LEN = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_on,
  input  logic chip_en_n,
  input  logic rd_req,
  input  logic flush_req_n,
  output logic start_o,
  output logic active_o
);
  localparam int CNTW = (QUAL_LEN > 1) ? $clog2(QUAL_LEN) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(QUAL_LEN - 1);

  flush_phase_t     phase_q;
  logic [CNTW-1:0]  cnt_q;
  logic             qual;

  // one qualifying sample: request low with all enable conditions met
  assign qual    = fifo_on && !chip_en_n && !rd_req && !flush_req_n;
  assign start_o = (phase_q == PH_WATCH) && qual && (cnt_q == LAST);
  assign active_o = (phase_q == PH_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WATCH;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_WATCH: begin
          if (start_o) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
          end else if (qual) begin
            cnt_q <= cnt_q + 1'b1;
          end else begin
            cnt_q <= '0;
          end
        end
        PH_HOLD: begin
          cnt_q <= '0;
          if (flush_req_n || !fifo_on) phase_q <= PH_WATCH;
        end
        default: phase_q <= PH_WATCH;
      endcase
    end
  end

  assert_start_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(qual));
  assert_bypass_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && !active_o) |=> !active_o);
  assert_hold_while_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !flush_req_n && fifo_on) |=> active_o);
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCW = $clog2(DEPTH + 1);
  localparam logic [OCW-1:0] OCC_MAX = OCW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [OCW-1:0]   occ_q;
  logic             do_wr, do_rd;

  assign empty_o = (occ_q == '0);
  assign full_o  = (occ_q == OCC_MAX);
  assign do_wr   = wr_en && !full_o && !clr;
  assign do_rd   = rd_en && !empty_o && !clr;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_nxt;
      if (do_rd) rd_ptr <= rd_nxt;
      unique case ({do_wr, do_rd})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_MAX);
  assert_full_ignores_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && wr_en && !rd_en && !clr) |=> ($stable(occ_q) && $stable(wr_ptr)));
  assert_empty_ignores_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && rd_en && !wr_en && !clr) |=> ($stable(rd_ptr) && occ_q == '0));
  assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (occ_q == '0 && wr_ptr == '0 && rd_ptr == '0));
  assert_stays_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !wr_en) |=> empty_o);
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int WIDTH    = 10,
  parameter int DEPTH    = 16,
  parameter int QUAL_LEN = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_on,
  input  logic             chip_en_n,
  input  logic             flush_req_n,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             empty,
  output logic             full
);
  logic             flush_start, flush_active, store_clr;
  logic             st_empty, st_full;
  logic [WIDTH-1:0] st_data;

  rxq_flush_qual #(.QUAL_LEN(QUAL_LEN)) u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_on     (fifo_on),
    .chip_en_n   (chip_en_n),
    .rd_req      (out_ready),
    .flush_req_n (flush_req_n),
    .start_o     (flush_start),
    .active_o    (flush_active)
  );

  assign store_clr = flush_start || flush_active;

  rxq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (store_clr),
    .wr_en   (fifo_on && in_valid),
    .wr_data (in_data),
    .rd_en   (fifo_on && out_ready),
    .rd_data (st_data),
    .empty_o (st_empty),
    .full_o  (st_full)
  );

  always_comb begin
    if (fifo_on) begin
      in_ready  = !st_full && !flush_active;
      out_valid = !st_empty && !flush_active;
      out_data  = st_data;
    end else begin
      in_ready  = out_ready;
      out_valid = in_valid;
      out_data  = in_data;
    end
  end

  assign empty = st_empty;
  assign full  = st_full;

  assert_no_accept_in_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && flush_active) |-> (!in_ready && !out_valid && empty));
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
endmodule

// File: tb/sim_rxq_fifo.sv
module sim_rxq_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int D = 4;
  localparam int QL = 7;

  logic clk = 1'b0;
  logic rst_n, fifo_on, chip_en_n, flush_req_n, in_valid, out_ready;
  logic [W-1:0] in_data;
  logic in_ready, out_valid, empty, full;
  logic [W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] model [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_fifo #(.WIDTH(W), .DEPTH(D), .QUAL_LEN(QL)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .chip_en_n(chip_en_n),
    .flush_req_n(flush_req_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .empty(empty), .full(full)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check_flags(input string tag);
    #1;
    chk(empty == (model.size() == 0), {tag, " empty"}, int'(empty), int'(model.size() == 0));
    chk(full == (model.size() == D), {tag, " R7 full"}, int'(full), int'(model.size() == D));
  endtask

  task automatic push(input logic [W-1:0] v);
    bit exp_rdy;
    in_data = v;
    in_valid = 1'b1;
    #1;
    exp_rdy = (model.size() < D);
    chk(in_ready == exp_rdy, "R7 in_ready", int'(in_ready), int'(exp_rdy));
    tick();
    in_valid = 1'b0;
    if (exp_rdy) model.push_back(v);
    check_flags("R9 push");
  endtask

  task automatic pop();
    bit exp_v;
    out_ready = 1'b1;
    #1;
    exp_v = (model.size() > 0);
    chk(out_valid == exp_v, "R8 out_valid", int'(out_valid), int'(exp_v));
    if (exp_v) chk(out_data == model[0], "R9 order", int'(out_data), int'(model[0]));
    tick();
    out_ready = 1'b0;
    if (exp_v) void'(model.pop_front());
    check_flags("R8 pop");
  endtask

  task automatic drain();
    while (model.size() > 0) pop();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fifo_on = 1'b1; chip_en_n = 1'b0; flush_req_n = 1'b1;
    in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // reset state: R5 empty, R8 no valid, R7 not full
    chk(empty == 1'b1, "R5 reset empty", int'(empty), 1);
    chk(full == 1'b0, "R7 reset full", int'(full), 0);
    chk(out_valid == 1'b0, "R8 reset out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R7 reset in_ready", int'(in_ready), 1);

    // R8: reads while empty ignored
    pop();
    pop();
    // R7/R9: fill past full, then drain
    for (int k = 0; k < D + 2; k++) push(W'(8'h30 + k));
    drain();
    // wrap-around pattern with interleaving
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k <= r + 1; k++) push(W'(8'h50 + 16*r + k));
      pop();
      push(W'(8'hA0 + r));
      drain();
    end

    // R1: sweep run length of qualifying samples with stored data
    for (int n = 1; n <= QL + 2; n++) begin
      push(W'(8'h10 + n));
      push(W'(8'h20 + n));
      flush_req_n = 1'b0;
      for (int c = 0; c < n; c++) tick();
      #1;
      if (n >= QL) begin
        chk(empty == 1'b1, "R1 R3 flushed empty", int'(empty), 1);
        chk(out_valid == 1'b0, "R4 out_valid in flush", int'(out_valid), 0);
        model.delete();
      end else begin
        chk(empty == 1'b0, "R1 early no flush", int'(empty), 0);
      end
      flush_req_n = 1'b1;
      tick();
      check_flags("R1 after run");
      drain();
    end

    // R2: single chip-disable edge restarts the count
    push(8'h77);
    flush_req_n = 1'b0;
    repeat (QL - 1) tick();
    chip_en_n = 1'b1;
    tick();
    chip_en_n = 1'b0;
    repeat (QL - 1) tick();
    #1 chk(empty == 1'b0, "R2 chip_en break", int'(empty), 0);
    tick();
    #1 chk(empty == 1'b1, "R2 fresh run flushes", int'(empty), 1);
    model.delete();
    // R4: held in flush, writes refused
    for (int k = 0; k < 3; k++) begin
      in_data = W'(8'hC0 + k);
      in_valid = 1'b1;
      #1 chk(in_ready == 1'b0, "R4 in_ready held", int'(in_ready), 0);
      tick();
      in_valid = 1'b0;
      #1 chk(empty == 1'b1, "R4 nothing stored", int'(empty), 1);
    end
    flush_req_n = 1'b1;
    // R5: empty stays until a write
    for (int k = 0; k < 3; k++) begin
      tick();
      #1 chk(empty == 1'b1, "R5 empty after release", int'(empty), 1);
    end
    push(8'h99);
    chk(empty == 1'b0, "R5 write clears empty", int'(empty), 0);
    drain();

    // R2: single high request edge restarts the count
    push(8'h66);
    flush_req_n = 1'b0;
    repeat (QL - 1) tick();
    flush_req_n = 1'b1;
    tick();
    flush_req_n = 1'b0;
    repeat (QL - 1) tick();
    #1 chk(empty == 1'b0, "R2 request break", int'(empty), 0);
    flush_req_n = 1'b1;
    tick();
    drain();

    // R6: bypass ignores request and passes data through
    push(8'h41);
    push(8'h42);
    fifo_on = 1'b0;
    flush_req_n = 1'b0;
    repeat (QL + 4) tick();
    in_data = 8'hA5; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk(out_valid == 1'b1, "R6 bypass valid", int'(out_valid), 1);
    chk(out_data == 8'hA5, "R6 bypass data", int'(out_data), 8'hA5);
    chk(in_ready == 1'b1, "R6 bypass ready", int'(in_ready), 1);
    tick();
    out_ready = 1'b0;
    #1 chk(in_ready == 1'b0, "R6 bypass backpressure", int'(in_ready), 0);
    in_valid = 1'b0;
    #1 chk(out_valid == 1'b0, "R6 bypass idle", int'(out_valid), 0);
    flush_req_n = 1'b1;
    tick();
    fifo_on = 1'b1;
    check_flags("R6 contents kept");
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule